// File: doc/BRIEF.md
# Machine Check Error Bank Logger

This block records hardware error reports in a parameterised set of error banks. Each bank has four 64-bit registers: an enable mask, a status word, a faulting address and an auxiliary word. A global section has three registers. A read-only capability register gives the bank count and says whether a global enable mask exists. A writable global enable mask and a global status word complete the section. Error sources present a report on an injection port. The port always completes the report in the cycle it is presented.

For each report, the logger takes one of four actions: ignore it, drop it, record it, or only mark an overflow on the existing entry. Uncorrected reports pass through two enable masks, one global and one per bank. An uncorrected report that is accepted raises a one-cycle machine-check pulse. An uncorrected report that arrives while a machine check is still in progress, or while the machine-check enable input is low, changes no bank. It raises a one-cycle shutdown pulse instead. Software reads and writes all registers through a simple register port. Through that port it acknowledges a handled event by clearing the in-progress flag and the bank valid bits.

Top module: `mcb_logger`

## Requirements
- R1: After reset, the global enable mask and every bank enable mask read all ones. Every bank status, address and auxiliary register reads zero, and the global status reads zero.
- R2: A report is ignored when its bank index is not less than the bank count (capability bits 7:0), or when its status bit 63 (valid) is clear. An ignored report changes no register and raises no pulse.
- R3: An uncorrected report (status bit 61 set) is dropped when capability bit 8 is set and the global enable mask is not all ones. Corrected reports are not affected by this mask.
- R4: An uncorrected report is dropped when the enable mask of the target bank is not all ones.
- R5: An uncorrected report that passes both masks, arriving while global status bit 2 (in progress) is set or while `mce_en_i` is low, leaves every bank unchanged. It raises `shutdown_o` for one cycle in the cycle after the report.
- R6: An accepted uncorrected report writes the bank address, the auxiliary word and the status, and copies the reported global status into the global status register. It sets status bit 62 (overflow) if the bank already held a valid entry. It raises `mce_o` for one cycle in the cycle after the report.
- R7: A corrected report replaces the bank address, auxiliary word and status when the existing entry is not valid or not uncorrected. It sets overflow if the existing entry was valid, and raises no pulse.
- R8: A corrected report into a bank that holds a valid uncorrected entry only sets that entry's overflow bit. The address and auxiliary word are left unchanged.
- R9: Register map: 0 is capability, 1 is the global enable mask, 2 is the global status. Bank b register k is at 4+4b+k, where k is 0 for enable mask, 1 for status, 2 for address and 3 for auxiliary. The capability register ignores writes and reads {bit 8 = global mask present, bits 7:0 = bank count}.
- R10: Software may write bank status, for example to clear the valid bit. A report to the same bank in the same cycle as a register write takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mce_en_i | input | 1 | Machine-check exception enable |
| inj_valid_i | input | 1 | Report present |
| inj_ready_o | output | 1 | Report accepted (always high) |
| inj_bank_i | input | 8 | Target bank index |
| inj_status_i | input | 64 | Reported bank status |
| inj_gstatus_i | input | 64 | Reported global status |
| inj_addr_i | input | 64 | Reported address |
| inj_misc_i | input | 64 | Reported auxiliary word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| mce_o | output | 1 | Machine-check pulse |
| shutdown_o | output | 1 | Shutdown request pulse |

## Verification
The bank state and the global status are the only memory this block has. A wrong gating decision therefore shows up in two ways. It either changes a register that can be read back in the cycle after the report, or it produces a wrong pulse on `mce_o` or `shutdown_o` in that same cycle. The corrected-report cases depend on the previous bank contents, so one sequence builds up history: an empty bank, then a corrected entry, then an uncorrected entry. An error in the overflow or keep-uncorrected logic then shows up as a wrong status word on the next readback.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned ST_VAL    = 63;
  localparam int unsigned ST_OVER   = 62;
  localparam int unsigned ST_UC     = 61;
  localparam int unsigned GS_MCIP   = 2;
  localparam int unsigned CAP_CTLP  = 8;
  localparam int unsigned BANK_BASE = 4;
  localparam int unsigned REGS_PER_BANK = 4;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_LOG,
    ACT_OVER,
    ACT_SHUT
  } act_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
(
  input  logic [IDX_W-1:0] bank_cnt_i,
  input  logic             ctlp_i,
  input  logic [XLEN-1:0]  gctl_i,
  input  logic [XLEN-1:0]  gstat_i,
  input  logic             mce_en_i,
  input  logic             inj_valid_i,
  input  logic [IDX_W-1:0] inj_bank_i,
  input  logic [XLEN-1:0]  inj_status_i,
  input  logic [XLEN-1:0]  bank_ctl_i,
  input  logic [XLEN-1:0]  bank_status_i,
  output act_e             act_o,
  output logic [XLEN-1:0]  new_status_o
);
  logic uc;
  assign uc = inj_status_i[ST_UC];

  always_comb begin
    act_o        = ACT_NONE;
    new_status_o = inj_status_i;
    if (!inj_valid_i || inj_bank_i >= bank_cnt_i || !inj_status_i[ST_VAL]) begin
      act_o = ACT_NONE;
    end else if (uc && ctlp_i && gctl_i != '1) begin
      act_o = ACT_NONE;
    end else if (uc && bank_ctl_i != '1) begin
      act_o = ACT_NONE;
    end else if (uc) begin
      if (gstat_i[GS_MCIP] || !mce_en_i) begin
        act_o = ACT_SHUT;
      end else begin
        act_o = ACT_LOG;
        if (bank_status_i[ST_VAL]) new_status_o[ST_OVER] = 1'b1;
      end
    end else if (!bank_status_i[ST_VAL] || !bank_status_i[ST_UC]) begin
      act_o = ACT_LOG;
      if (bank_status_i[ST_VAL]) new_status_o[ST_OVER] = 1'b1;
    end else begin
      act_o = ACT_OVER;
    end
  end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
  import mcb_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [REGS_PER_BANK-1:0] sw_we_i,
  input  logic [XLEN-1:0]          sw_wdata_i,
  input  logic                     log_i,
  input  logic                     over_i,
  input  logic [XLEN-1:0]          log_status_i,
  input  logic [XLEN-1:0]          log_addr_i,
  input  logic [XLEN-1:0]          log_misc_i,
  output logic [XLEN-1:0]          ctl_o,
  output logic [XLEN-1:0]          status_o,
  output logic [XLEN-1:0]          addr_o,
  output logic [XLEN-1:0]          misc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o    <= '1;
      status_o <= '0;
      addr_o   <= '0;
      misc_o   <= '0;
    end else begin
      if (sw_we_i[0]) ctl_o <= sw_wdata_i;
      if (log_i) begin
        status_o <= log_status_i;
        addr_o   <= log_addr_i;
        misc_o   <= log_misc_i;
      end else if (over_i) begin
        status_o[ST_OVER] <= 1'b1;
      end else begin
        // injection wins over software on the same bank
        if (sw_we_i[1]) status_o <= sw_wdata_i;
        if (sw_we_i[2]) addr_o   <= sw_wdata_i;
        if (sw_we_i[3]) misc_o   <= sw_wdata_i;
      end
    end
  end

  AST_LOG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_i |=> status_o == $past(log_status_i)) else $error("log"); // R10
  AST_OVER_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_i |=> status_o[ST_OVER] && addr_o == $past(addr_o) && misc_o == $past(misc_o)) else $error("over"); // R8
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 4,
  parameter int unsigned CPU_FAMILY   = 6,
  parameter bit          HAS_MC_EXC   = 1'b1,
  parameter bit          HAS_MC_ARCH  = 1'b1,
  parameter bit          GCTL_PRESENT = 1'b1,
  localparam int unsigned AW = $clog2(BANK_BASE + REGS_PER_BANK * NUM_BANKS),
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mce_en_i,
  input  logic             inj_valid_i,
  output logic             inj_ready_o,
  input  logic [IDX_W-1:0] inj_bank_i,
  input  logic [XLEN-1:0]  inj_status_i,
  input  logic [XLEN-1:0]  inj_gstatus_i,
  input  logic [XLEN-1:0]  inj_addr_i,
  input  logic [XLEN-1:0]  inj_misc_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [XLEN-1:0]  reg_wdata_i,
  output logic [XLEN-1:0]  reg_rdata_o,
  output logic             mce_o,
  output logic             shutdown_o
);
  localparam bit MC_OK = (CPU_FAMILY >= 6) && HAS_MC_EXC && HAS_MC_ARCH;
  localparam logic [IDX_W-1:0] BANK_CNT = MC_OK ? IDX_W'(NUM_BANKS) : '0;

  logic [XLEN-1:0] cap, gctl_q, gstat_q;
  logic [XLEN-1:0] b_ctl [NUM_BANKS];
  logic [XLEN-1:0] b_st  [NUM_BANKS];
  logic [XLEN-1:0] b_adr [NUM_BANKS];
  logic [XLEN-1:0] b_msc [NUM_BANKS];
  logic [XLEN-1:0] sel_ctl, sel_st, new_status;
  logic [BW-1:0]   sel;
  logic            in_rng;
  act_e            act;

  assign cap         = {{(XLEN-IDX_W-1){1'b0}}, GCTL_PRESENT, BANK_CNT};
  assign inj_ready_o = 1'b1;
  assign in_rng      = inj_bank_i < IDX_W'(NUM_BANKS);
  assign sel         = in_rng ? inj_bank_i[BW-1:0] : '0;
  assign sel_ctl     = b_ctl[sel];
  assign sel_st      = b_st[sel];

  mcb_decide u_decide (
    .bank_cnt_i   (BANK_CNT),
    .ctlp_i       (cap[CAP_CTLP]),
    .gctl_i       (gctl_q),
    .gstat_i      (gstat_q),
    .mce_en_i     (mce_en_i),
    .inj_valid_i  (inj_valid_i),
    .inj_bank_i   (inj_bank_i),
    .inj_status_i (inj_status_i),
    .bank_ctl_i   (sel_ctl),
    .bank_status_i(sel_st),
    .act_o        (act),
    .new_status_o (new_status)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [REGS_PER_BANK-1:0] we;
    logic hit;
    assign hit = in_rng && (sel == BW'(b));
    for (genvar k = 0; k < REGS_PER_BANK; k++) begin : g_we
      assign we[k] = reg_we_i && (reg_addr_i == AW'(BANK_BASE + REGS_PER_BANK * b + k));
    end
    mcb_bank u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sw_we_i     (we),
      .sw_wdata_i  (reg_wdata_i),
      .log_i       (hit && act == ACT_LOG),
      .over_i      (hit && act == ACT_OVER),
      .log_status_i(new_status),
      .log_addr_i  (inj_addr_i),
      .log_misc_i  (inj_misc_i),
      .ctl_o       (b_ctl[b]),
      .status_o    (b_st[b]),
      .addr_o      (b_adr[b]),
      .misc_o      (b_msc[b])
    );
  end

  logic uc_log;
  assign uc_log = (act == ACT_LOG) && inj_status_i[ST_UC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q     <= '1;
      gstat_q    <= '0;
      mce_o      <= 1'b0;
      shutdown_o <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == AW'(1)) gctl_q <= reg_wdata_i;
      if (uc_log) gstat_q <= inj_gstatus_i;
      else if (reg_we_i && reg_addr_i == AW'(2)) gstat_q <= reg_wdata_i;
      mce_o      <= uc_log;
      shutdown_o <= (act == ACT_SHUT);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(0): reg_rdata_o = cap;
      AW'(1): reg_rdata_o = gctl_q;
      AW'(2): reg_rdata_o = gstat_q;
      default: ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr_i == AW'(BANK_BASE + REGS_PER_BANK * b + 0)) reg_rdata_o = b_ctl[b];
      if (reg_addr_i == AW'(BANK_BASE + REGS_PER_BANK * b + 1)) reg_rdata_o = b_st[b];
      if (reg_addr_i == AW'(BANK_BASE + REGS_PER_BANK * b + 2)) reg_rdata_o = b_adr[b];
      if (reg_addr_i == AW'(BANK_BASE + REGS_PER_BANK * b + 3)) reg_rdata_o = b_msc[b];
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mce_o && shutdown_o)) else $error("both pulses"); // R5
  AST_IGNORED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && (inj_bank_i >= BANK_CNT || !inj_status_i[ST_VAL])) |=> !mce_o && !shutdown_o)
    else $error("ignored report pulsed"); // R2
  AST_MCE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mce_o) |-> $past(inj_valid_i && inj_status_i[ST_UC] && mce_en_i)) else $error("mce cause"); // R6
  AST_SHUT_NO_GSTAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_SHUT && !reg_we_i) |=> $stable(gstat_q)) else $error("shutdown touched gstat"); // R5
endmodule

// File: tb/tb_mcb_logger.sv
module tb_mcb_logger;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = $clog2(4 + 4 * NB);
  localparam logic [63:0] V = 64'h1 << 63;
  localparam logic [63:0] O = 64'h1 << 62;
  localparam logic [63:0] U = 64'h1 << 61;

  logic clk = 0, rst_n = 0, mce_en = 1;
  logic inj_valid = 0, inj_ready;
  logic [7:0] inj_bank = 0;
  logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic mce, shutdown;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcb_logger #(.NUM_BANKS(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mce_en_i(mce_en),
    .inj_valid_i(inj_valid), .inj_ready_o(inj_ready), .inj_bank_i(inj_bank),
    .inj_status_i(inj_status), .inj_gstatus_i(inj_gstatus),
    .inj_addr_i(inj_addr), .inj_misc_i(inj_misc),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .mce_o(mce), .shutdown_o(shutdown)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [63:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(string tag, int a, logic [63:0] exp);
    logic [63:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  // presents one report; returns pulses seen in the following cycle
  task automatic inject(int b, logic [63:0] st, logic [63:0] gs, logic [63:0] ad,
                        logic [63:0] ms, output logic m, output logic s);
    @(negedge clk);
    inj_valid = 1; inj_bank = 8'(b); inj_status = st; inj_gstatus = gs;
    inj_addr = ad; inj_misc = ms;
    @(negedge clk);
    inj_valid = 0;
    m = mce; s = shutdown;
  endtask

  task automatic t_reset;
    chk_reg("R1 gctl", 1, '1);
    chk_reg("R1 gstat", 2, 0);
    for (int b = 0; b < NB; b++) begin
      chk_reg("R1 bank ctl", 4 + 4*b, '1);
      chk_reg("R1 bank status", 5 + 4*b, 0);
      chk_reg("R1 bank addr", 6 + 4*b, 0);
    end
    chk("R1 pulses", {62'b0, mce, shutdown}, 0);
  endtask

  task automatic t_ignore;
    logic m, s;
    inject(NB, V | U | 64'h1, 64'h4, 64'hA, 64'hB, m, s);
    chk("R2 out-of-range pulses", {62'b0, m, s}, 0);
    for (int b = 0; b < NB; b++) chk_reg("R2 out-of-range status", 5 + 4*b, 0);
    inject(0, 64'h1, 0, 64'hA, 0, m, s);
    chk("R2 invalid status", {62'b0, m, s}, 0);
    chk_reg("R2 invalid bank0", 5, 0);
    chk_reg("R2 invalid addr0", 6, 0);
  endtask

  task automatic t_corrected;
    logic m, s;
    inject(1, V | 64'h11, 0, 64'hA1, 64'hC1, m, s);
    chk("R7 no pulse", {62'b0, m, s}, 0);
    chk_reg("R7 status", 5 + 4, V | 64'h11);
    chk_reg("R7 addr", 6 + 4, 64'hA1);
    chk_reg("R7 misc", 7 + 4, 64'hC1);
    inject(1, V | 64'h22, 0, 64'hA2, 64'hC2, m, s);
    chk_reg("R7 over status", 5 + 4, V | O | 64'h22);
    chk_reg("R7 over addr", 6 + 4, 64'hA2);
  endtask

  task automatic t_uc_accept;
    logic m, s;
    inject(2, V | U | 64'h5, 64'h5, 64'hA3, 64'hC3, m, s);
    chk("R6 mce", m, 1);
    chk("R6 no shutdown", s, 0);
    chk_reg("R6 status", 5 + 8, V | U | 64'h5);
    chk_reg("R6 gstat", 2, 64'h5);
    chk_reg("R6 misc", 7 + 8, 64'hC3);
    @(negedge clk);
    chk("R6 mce one cycle", mce, 0);
  endtask

  task automatic t_ce_after_uc;
    logic m, s;
    inject(2, V | 64'h33, 0, 64'hA4, 64'hC4, m, s);
    chk("R8 no pulse", {62'b0, m, s}, 0);
    chk_reg("R8 status", 5 + 8, V | U | O | 64'h5);
    chk_reg("R8 addr kept", 6 + 8, 64'hA3);
    chk_reg("R8 misc kept", 7 + 8, 64'hC3);
  endtask

  task automatic t_shutdown;
    logic m, s;
    inject(3, V | U | 64'h7, 0, 64'hA6, 0, m, s);
    chk("R5 shutdown in progress", s, 1);
    chk("R5 no mce", m, 0);
    chk_reg("R5 bank3 untouched", 5 + 12, 0);
    chk_reg("R5 gstat kept", 2, 64'h5);
    @(negedge clk);
    chk("R5 shutdown one cycle", shutdown, 0);
    wr(2, 0);
    chk_reg("R5 gstat cleared", 2, 0);
    mce_en = 0;
    inject(3, V | U | 64'h7, 64'h4, 64'hA6, 0, m, s);
    chk("R5 shutdown disabled", s, 1);
    chk_reg("R5 bank3 untouched dis", 5 + 12, 0);
    mce_en = 1;
  endtask

  task automatic t_uc_over;
    logic m, s;
    inject(1, V | U | 64'h9, 64'h4, 64'hA5, 64'hC5, m, s);
    chk("R6 mce over", m, 1);
    chk_reg("R6 over status", 5 + 4, V | U | O | 64'h9);
    chk_reg("R6 over addr", 6 + 4, 64'hA5);
    wr(2, 0);
  endtask

  task automatic t_gctl_drop;
    logic m, s;
    wr(1, 64'h0);
    inject(0, V | U | 64'h1, 64'h4, 64'hAA, 0, m, s);
    chk("R3 drop pulses", {62'b0, m, s}, 0);
    chk_reg("R3 drop bank0", 5, 0);
    chk_reg("R3 gstat kept", 2, 0);
    inject(0, V | 64'h2, 0, 64'hAB, 0, m, s);
    chk_reg("R3 corrected still logs", 5, V | 64'h2);
    wr(1, '1);
  endtask

  task automatic t_bctl_drop;
    logic m, s;
    wr(4 + 12, 64'hFF);
    inject(3, V | U | 64'h3, 64'h4, 64'hAC, 0, m, s);
    chk("R4 drop pulses", {62'b0, m, s}, 0);
    chk_reg("R4 drop bank3", 5 + 12, 0);
    wr(4 + 12, '1);
    inject(3, V | U | 64'h3, 64'h0, 64'hAC, 0, m, s);
    chk("R4 accepted after restore", m, 1);
  endtask

  task automatic t_cap;
    wr(0, 64'hDEAD);
    chk_reg("R9 cap read-only", 0, 64'h104);
  endtask

  task automatic t_priority;
    logic m, s;
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(5); reg_wdata = 0;
    inj_valid = 1; inj_bank = 0; inj_status = V | 64'h4; inj_gstatus = 0;
    inj_addr = 64'hAD; inj_misc = 0;
    @(negedge clk);
    reg_we = 0; inj_valid = 0;
    chk_reg("R10 injection wins", 5, V | O | 64'h4);
    wr(5, 0);
    chk_reg("R10 sw clear", 5, 0);
    inject(0, V | 64'h6, 0, 64'hAE, 0, m, s);
    chk_reg("R10 logs fresh after clear", 5, V | 64'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_corrected();
    t_uc_accept();
    t_ce_after_uc();
    t_shutdown();
    t_uc_over();
    t_gctl_drop();
    t_bctl_drop();
    t_cap();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule